// File: doc/BRIEF.md
# Shared Interrupt Line Router

This block steers eight shared, level-sensitive PCI interrupt requests (PIRQ A to H) and one system-control interrupt (SCI) onto two sets of outputs. The first set is 16 legacy controller lines. The second set is eight I/O-APIC lines, which stand for global inputs 16 to 23.

Each PIRQ always drives its own APIC input, and nothing else shares that input. Each PIRQ can also be steered to one legacy line through its own route byte, and several PIRQs may share the same legacy line. An ACPI control byte selects the line that carries the SCI. That line can be a legacy line or an APIC line, and the SCI is ORed into it.

The block also reports, for each PIRQ, whether its legacy route is active and which legacy line it uses. A platform integrator programs the route bytes through a simple byte-write port.

All interrupt inputs and outputs are plain levels. They are not valid/ready streams, so there is no back-pressure. A level presented on an input is reflected on the outputs one clock later.

Top module: `pirq_router`

## Requirements
- R1: Configuration is written one byte at a time. Addresses 0 to 3 hold the route bytes of PIRQ A to D, addresses 4 to 7 hold those of PIRQ E to H, and address 8 holds the SCI control byte. A write to any address from 9 to 15 changes nothing. A written value takes effect on the outputs one clock after the write edge.
- R2: In a route byte, bits 3:0 give the legacy line number and bit 7 is a disable flag. When bit 7 is set, that PIRQ contributes to no legacy line.
- R3: Each legacy line is the OR of every enabled PIRQ routed to it. The sampled SCI level is also ORed in when the SCI selection names that line.
- R4: APIC output n is driven by PIRQ n alone, whatever its route byte says. The SCI is ORed into APIC output 4 when the selection is line 20, and into APIC output 5 when it is line 21.
- R5: Bits 2:0 of the SCI control byte select the SCI line: 000 selects 9, 001 selects 10, 010 selects 11, 100 selects 20 and 101 selects 21. The codes 011, 110 and 111 route the SCI nowhere. Bits 7:3 are ignored.
- R6: `route_en[n]` is 1 exactly when PIRQ n has its disable bit clear and a line number below 16. In that case `route_num` field n (bits 4n+3:4n) holds the line number. Otherwise that field is 0.
- R7: Reset loads 0x80 (disabled) into all eight route bytes and 0x00 into the SCI control byte, so the SCI goes to line 9. Reset also clears the sampled input levels, so all outputs read 0.
- R8: A change of `pirq_lvl` or `sci_lvl` appears on `legacy_irq` and `apic_irq` after exactly one rising clock edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_addr | input | 4 | Configuration byte address |
| cfg_wdata | input | 8 | Configuration byte data |
| pirq_lvl | input | 8 | Shared interrupt request levels, bit n is PIRQ n |
| sci_lvl | input | 1 | System-control interrupt level |
| legacy_irq | output | 16 | Legacy controller line levels |
| apic_irq | output | 8 | APIC input levels for global inputs 16 to 23 |
| route_en | output | 8 | Per-PIRQ legacy route active |
| route_num | output | 32 | Per-PIRQ legacy line number, four bits per PIRQ |

## Verification
The checker watches several properties on every cycle:
- A disabled route always reports line 0.
- With the SCI low, the APIC outputs follow the PIRQ inputs of the previous cycle.
- All-low inputs give all-low outputs one cycle later.
- With every route disabled and the SCI low, no legacy line is ever high.
- Reset always leaves all routes disabled.

Some behaviours can only be shown by the bench's scenarios:
- the OR-sharing of several PIRQs on one line;
- the five SCI encodings and the three codes that route nowhere;
- the writes to unused addresses that must be ignored;
- the exact one-cycle latency.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
  localparam int RT_DIS_BIT = 7;
  localparam logic [7:0] RT_RESET = 8'h80;
  localparam logic [7:0] SCI_CTRL_RESET = 8'h00;
  localparam int SCI_LINE_W = 5;

  typedef struct packed {
    logic                  valid;
    logic [SCI_LINE_W-1:0] line;
  } sci_sel_t;

  function automatic sci_sel_t sci_decode(input logic [2:0] code);
    sci_sel_t s;
    s.valid = 1'b1;
    unique case (code)
      3'b000:  s.line = 5'd9;
      3'b001:  s.line = 5'd10;
      3'b010:  s.line = 5'd11;
      3'b100:  s.line = 5'd20;
      3'b101:  s.line = 5'd21;
      default: begin s.valid = 1'b0; s.line = '0; end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/pirq_cfg_regs.sv
module pirq_cfg_regs #(
  parameter int N_PIRQ = 8,
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  output logic [N_PIRQ-1:0][7:0] route,
  output logic [7:0]             sci_ctrl
);
  import pirq_pkg::*;

  for (genvar i = 0; i < N_PIRQ; i++) begin : g_rt
    always_ff @(posedge clk) begin
      if (!rst_n) route[i] <= RT_RESET;
      else if (we && addr == ADDR_W'(i)) route[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sci_ctrl <= SCI_CTRL_RESET;
    else if (we && addr == ADDR_W'(N_PIRQ)) sci_ctrl <= wdata;
  end
endmodule

// File: rtl/pirq_sci_dec.sv
module pirq_sci_dec #(
  parameter int N_PIRQ = 8,
  parameter int LEG    = 16
) (
  input  logic [7:0]        sci_ctrl,
  output logic [LEG-1:0]    leg_hit,
  output logic [N_PIRQ-1:0] apic_hit
);
  import pirq_pkg::*;
  sci_sel_t sel;

  always_comb begin
    sel = sci_decode(sci_ctrl[2:0]);
    for (int k = 0; k < LEG; k++)
      leg_hit[k] = sel.valid && (int'(sel.line) == k);
    for (int k = 0; k < N_PIRQ; k++)
      apic_hit[k] = sel.valid && (int'(sel.line) == k + LEG);
  end
endmodule

// File: rtl/pirq_line_mux.sv
module pirq_line_mux #(
  parameter int N_PIRQ = 8,
  parameter int LEG    = 16,
  localparam int NW    = $clog2(LEG)
) (
  input  logic [N_PIRQ-1:0][7:0] route,
  input  logic [N_PIRQ-1:0]      pirq_q,
  input  logic                   sci_q,
  input  logic [LEG-1:0]         sci_leg_hit,
  input  logic [N_PIRQ-1:0]      sci_apic_hit,
  output logic [LEG-1:0]         legacy,
  output logic [N_PIRQ-1:0]      apic,
  output logic [N_PIRQ-1:0]      en,
  output logic [N_PIRQ*NW-1:0]   num
);
  import pirq_pkg::*;

  always_comb begin
    legacy = sci_leg_hit & {LEG{sci_q}};
    for (int i = 0; i < N_PIRQ; i++) begin
      en[i] = !route[i][RT_DIS_BIT] && (int'(route[i][NW-1:0]) < LEG);
      num[i*NW +: NW] = en[i] ? route[i][NW-1:0] : '0;
      for (int k = 0; k < LEG; k++)
        if (en[i] && pirq_q[i] && int'(route[i][NW-1:0]) == k)
          legacy[k] = 1'b1;
    end
    apic = pirq_q | (sci_apic_hit & {N_PIRQ{sci_q}});
  end
endmodule

// File: rtl/pirq_router.sv
module pirq_router #(
  parameter int N_PIRQ  = 8,
  parameter int LEG     = 16,
  localparam int NW     = $clog2(LEG),
  localparam int ADDR_W = $clog2(2 * N_PIRQ)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [ADDR_W-1:0]    cfg_addr,
  input  logic [7:0]           cfg_wdata,
  input  logic [N_PIRQ-1:0]    pirq_lvl,
  input  logic                 sci_lvl,
  output logic [LEG-1:0]       legacy_irq,
  output logic [N_PIRQ-1:0]    apic_irq,
  output logic [N_PIRQ-1:0]    route_en,
  output logic [N_PIRQ*NW-1:0] route_num
);
  logic [N_PIRQ-1:0][7:0] route;
  logic [7:0]             sci_ctrl;
  logic [LEG-1:0]         sci_leg_hit;
  logic [N_PIRQ-1:0]      sci_apic_hit;
  logic [N_PIRQ-1:0]      pirq_q;
  logic                   sci_q;

  // Sampled levels; the SCI state only moves when the level differs.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pirq_q <= '0;
      sci_q  <= 1'b0;
    end else begin
      pirq_q <= pirq_lvl;
      if (sci_lvl != sci_q) sci_q <= sci_lvl;
    end
  end

  pirq_cfg_regs #(.N_PIRQ(N_PIRQ), .ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .route(route), .sci_ctrl(sci_ctrl)
  );

  pirq_sci_dec #(.N_PIRQ(N_PIRQ), .LEG(LEG)) u_sci (
    .sci_ctrl(sci_ctrl), .leg_hit(sci_leg_hit), .apic_hit(sci_apic_hit)
  );

  pirq_line_mux #(.N_PIRQ(N_PIRQ), .LEG(LEG)) u_mux (
    .route(route), .pirq_q(pirq_q), .sci_q(sci_q),
    .sci_leg_hit(sci_leg_hit), .sci_apic_hit(sci_apic_hit),
    .legacy(legacy_irq), .apic(apic_irq), .en(route_en), .num(route_num)
  );
endmodule

// File: rtl/pirq_router_chk.sv
module pirq_router_chk #(
  parameter int N_PIRQ  = 8,
  parameter int LEG     = 16,
  localparam int NW     = $clog2(LEG)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [N_PIRQ-1:0]    pirq_lvl,
  input logic                 sci_lvl,
  input logic [LEG-1:0]       legacy_irq,
  input logic [N_PIRQ-1:0]    apic_irq,
  input logic [N_PIRQ-1:0]    route_en,
  input logic [N_PIRQ*NW-1:0] route_num
);
  p_apic_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sci_lvl |=> apic_irq == $past(pirq_lvl));

  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pirq_lvl == '0 && !sci_lvl) |=> (legacy_irq == '0 && apic_irq == '0));

  p_legacy_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (route_en == '0 && !$past(sci_lvl)) |-> legacy_irq == '0);

  p_reset_cfg_r7: assert property (@(posedge clk)
    $rose(rst_n) |-> route_en == '0);

  for (genvar i = 0; i < N_PIRQ; i++) begin : g_st
    p_status_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !route_en[i] |-> route_num[i*NW +: NW] == '0);
  end
endmodule

bind pirq_router pirq_router_chk #(.N_PIRQ(N_PIRQ), .LEG(LEG)) u_chk (
  .clk(clk), .rst_n(rst_n), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
  .legacy_irq(legacy_irq), .apic_irq(apic_irq),
  .route_en(route_en), .route_num(route_num)
);

// File: tb/pirq_router_tb.sv
module pirq_router_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [7:0]  pirq_lvl = '0;
  logic        sci_lvl = 1'b0;
  logic [15:0] legacy_irq;
  logic [7:0]  apic_irq;
  logic [7:0]  route_en;
  logic [31:0] route_num;
  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  pirq_router u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .pirq_lvl(pirq_lvl), .sci_lvl(sci_lvl),
    .legacy_irq(legacy_irq), .apic_irq(apic_irq),
    .route_en(route_en), .route_num(route_num)
  );

  // {pirq, sci, expected legacy, expected apic} under the R3 table setup
  localparam logic [32:0] VEC [11] = '{
    {8'h00, 1'b0, 16'h0000, 8'h00},
    {8'h01, 1'b0, 16'h0020, 8'h01},
    {8'h02, 1'b0, 16'h0020, 8'h02},
    {8'h08, 1'b0, 16'h0000, 8'h08},
    {8'h04, 1'b0, 16'h0800, 8'h04},
    {8'h00, 1'b1, 16'h0800, 8'h00},
    {8'h10, 1'b0, 16'h0200, 8'h10},
    {8'h20, 1'b0, 16'h0008, 8'h20},
    {8'h40, 1'b0, 16'h8000, 8'h40},
    {8'h80, 1'b0, 16'h0000, 8'h80},
    {8'hFF, 1'b1, 16'h8A28, 8'hFF}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic drive(input logic [7:0] p, input logic s);
    pirq_lvl = p; sci_lvl = s;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 route_en", 32'(route_en), 32'h0);
    check("R7 route_num", route_num, 32'h0);
    check("R7 legacy", 32'(legacy_irq), 32'h0);
    check("R7 apic", 32'(apic_irq), 32'h0);
    drive(8'h00, 1'b1);
    check("R7 default SCI line 9", 32'(legacy_irq), 32'h0200);
    drive(8'h01, 1'b0);
    check("R2 default routes disabled", 32'(legacy_irq), 32'h0);
    drive(8'h00, 1'b0);

    // R1 setup
    wr(4'd0, 8'h05); wr(4'd1, 8'h05); wr(4'd2, 8'h0B); wr(4'd3, 8'h85);
    wr(4'd4, 8'h09); wr(4'd5, 8'h03); wr(4'd6, 8'h0F); wr(4'd8, 8'h02);
    check("R6 route_en", 32'(route_en), 32'h77);
    check("R6 route_num", route_num, 32'h0F390B55);

    // R3 table walk
    for (int i = 0; i < 11; i++) begin
      drive(VEC[i][32:25], VEC[i][24]);
      check("R3 legacy", 32'(legacy_irq), 32'(VEC[i][23:8]));
      check("R4 apic", 32'(apic_irq), 32'(VEC[i][7:0]));
    end

    // R8 latency
    drive(8'h00, 1'b0);
    pirq_lvl = 8'h01;
    #1 check("R8 no early change", 32'(legacy_irq), 32'h0);
    @(negedge clk);
    check("R8 one clock", 32'(legacy_irq), 32'h0020);
    drive(8'h00, 1'b0);

    // R1 unused addresses ignored
    wr(4'd9, 8'h04); wr(4'd15, 8'h85);
    drive(8'h00, 1'b1);
    check("R1 ignored write SCI", 32'(legacy_irq), 32'h0800);
    check("R1 ignored write status", route_num, 32'h0F390B55);

    // R5 encodings
    wr(4'd8, 8'h04);
    check("R5 sel 20 apic", 32'(apic_irq), 32'h10);
    check("R5 sel 20 legacy", 32'(legacy_irq), 32'h0);
    wr(4'd8, 8'h05);
    check("R5 sel 21 apic", 32'(apic_irq), 32'h20);
    wr(4'd8, 8'h03);
    check("R5 code 3 none", {legacy_irq, 8'h00, apic_irq}, 32'h0);
    wr(4'd8, 8'h07);
    check("R5 code 7 none", {legacy_irq, 8'h00, apic_irq}, 32'h0);
    wr(4'd8, 8'h01);
    check("R5 sel 10", 32'(legacy_irq), 32'h0400);
    wr(4'd8, 8'hF8);
    check("R5 upper bits ignored", 32'(legacy_irq), 32'h0200);

    // R4 SCI shares APIC input of PIRQ E
    wr(4'd8, 8'h04);
    drive(8'h10, 1'b1);
    check("R4 apic shared", 32'(apic_irq), 32'h10);
    check("R4 legacy of E", 32'(legacy_irq), 32'h0200);
    drive(8'h10, 1'b0);
    check("R4 apic E alone", 32'(apic_irq), 32'h10);

    // R2 re-disable A keeps B on line 5
    wr(4'd0, 8'h85);
    drive(8'h01, 1'b0);
    check("R2 disabled A", 32'(legacy_irq), 32'h0);
    check("R6 A status", 32'(route_en), 32'h76);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule